// File: doc/BRIEF.md
# Virtual Processor Run/Stop Controller

This block sits on a simple register bus and decides which virtual processors (VPs) of a cluster are executing. Software starts VPs by writing a bit mask to a start command register and halts them by writing a mask to a halt command register. Both registers act only on the bits written as one. A status register reports which VPs are currently marked running. A VP receives a one-cycle reset-and-start pulse only when it moves from stopped to running. A VP receives a one-cycle halt request only when it moves from running to stopped.

The same three registers appear in two address windows, a local window and an other-core window. The two windows behave identically. The number of VPs and the set of VPs that come up running after reset are parameters. A start set that names VPs which do not exist is rejected at elaboration.

Top module: `vpc_run_ctrl`

## Requirements
- R1: Write data bits at positions NUM_VP and above are ignored by both commands, and read data bits at positions NUM_VP and above are always zero.
- R2: A write to the start register (offset 0x0) makes each stopped VP whose data bit is 1 receive a reset pulse exactly one cycle after the write edge. Its running bit becomes 1 in that same cycle. The pulse lasts one cycle.
- R3: A start write for a VP that is already running produces no reset pulse and leaves its running bit at 1.
- R4: A write to the halt register (offset 0x8) makes each running VP whose data bit is 1 receive a one-cycle halt request one cycle after the write edge. Its running bit becomes 0 in that same cycle.
- R5: A halt write for a VP that is already stopped produces no halt request and leaves the running vector unchanged.
- R6: A read of the status register (offset 0x10) returns the running vector, zero-extended, on the read data port one cycle after the read edge. Read data is zero in every cycle that does not follow a status read.
- R7: The registers are decoded at base 0x2000 (local window) and at base 0x4000 (other-core window) with the same offsets, and both windows have the same effect.
- R8: A write to any other address changes no output, and a read from any other address returns zero.
- R9: While reset is held, the running vector and both pulse vectors are zero. In the first cycle after reset is released, the VPs in START_RUNNING receive a reset pulse and are marked running.
- R10: A VP that was halted and is then started again receives a new reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data mask |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| vp_start_pulse | output | NUM_VP | One-cycle reset-and-start pulse per VP |
| vp_halt_req | output | NUM_VP | One-cycle halt request per VP |
| vp_running | output | NUM_VP | Running status per VP |

## Verification
The hardest case to reach is a command whose mask overlaps VPs in both states. In that case the block must filter the mask per bit against the current running vector, so that one write pulses some VPs and leaves others untouched. The stimulus table therefore first builds a mixed running vector from the reset-time start set. It then writes start and halt masks that cover running VPs, stopped VPs and bits above NUM_VP together, and alternates between the two windows. A reset applied in the middle of the run shows that the start set is issued again from an all-stopped state.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RUN  = 2'd1,
    CMD_STOP = 2'd2,
    CMD_STAT = 2'd3
  } vpc_cmd_e;

  localparam int NUM_WIN = 2;

  // Register offsets inside a window; software depends on these values.
  localparam logic [7:0] OFS_RUN  = 8'h00;
  localparam logic [7:0] OFS_STOP = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h10;

  // Valid-VP mask for n implemented VPs, widened to 64 bits.
  function automatic logic [63:0] vp_mask(input int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // Classify a window-relative offset.
  function automatic vpc_cmd_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_RUN:  return CMD_RUN;
      OFS_STOP: return CMD_STOP;
      OFS_STAT: return CMD_STAT;
      default:  return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vpc_addr_decode.sv
module vpc_addr_decode
  import vpc_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 16'h2000,
  parameter logic [ADDR_W-1:0] REMOTE_BASE = 16'h4000,
  parameter int                WIN_SPAN    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              run_wr,
  output logic              stop_wr,
  output logic              stat_rd
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WIN_SPAN);

  logic     [NUM_WIN-1:0] win_hit;
  vpc_cmd_e               win_cmd [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = (w == 0) ? LOCAL_BASE : REMOTE_BASE;
    logic [ADDR_W-1:0] rel;
    always_comb begin
      rel        = addr - BASE;
      win_hit[w] = (addr >= BASE) && (rel < SPAN);
      win_cmd[w] = win_hit[w] ? decode_ofs(rel[7:0]) : CMD_NONE;
    end
  end

  vpc_cmd_e cmd;
  always_comb begin
    cmd = CMD_NONE;
    for (int w = 0; w < NUM_WIN; w++)
      if (win_hit[w]) cmd = win_cmd[w];
  end

  assign run_wr  = we && (cmd == CMD_RUN);
  assign stop_wr = we && (cmd == CMD_STOP);
  assign stat_rd = re && (cmd == CMD_STAT);

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_wr, stop_wr, stat_rd})); // R7

  AST_NO_CMD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !re) |-> !(run_wr || stop_wr || stat_rd)); // R8

endmodule

// File: rtl/vpc_run_state.sv
module vpc_run_state
  import vpc_pkg::*;
#(
  parameter int          NUM_VP        = 1,
  parameter logic [63:0] START_RUNNING = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_wr,
  input  logic              stop_wr,
  input  logic [NUM_VP-1:0] cmd_mask,
  output logic [NUM_VP-1:0] running,
  output logic [NUM_VP-1:0] start_pulse,
  output logic [NUM_VP-1:0] halt_req
);

  localparam logic [NUM_VP-1:0] BOOT_SET = START_RUNNING[NUM_VP-1:0];

  if (START_RUNNING > vp_mask(NUM_VP)) begin : g_bad_start
    $error("START_RUNNING names VPs beyond NUM_VP");
  end

  logic              boot_q;
  logic [NUM_VP-1:0] want_run;
  logic [NUM_VP-1:0] start_set;
  logic [NUM_VP-1:0] stop_set;

  always_comb begin
    want_run  = (boot_q ? BOOT_SET : '0) | (run_wr ? cmd_mask : '0);
    start_set = want_run & ~running;
    stop_set  = stop_wr ? (cmd_mask & running) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q      <= 1'b1;
      running     <= '0;
      start_pulse <= '0;
      halt_req    <= '0;
    end else begin
      boot_q      <= 1'b0;
      running     <= (running | start_set) & ~stop_set;
      start_pulse <= start_set;
      halt_req    <= stop_set;
    end
  end

  AST_START_MARKS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse & ~running) == '0); // R2

  AST_NO_PULSE_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse & $past(running)) == '0); // R3

  AST_HALT_CLEARS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req & running) == '0); // R4

  AST_HALT_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req & ~$past(running)) == '0); // R5

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse != '0) |=> ((start_pulse & $past(start_pulse)) == '0)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (running == '0 && start_pulse == '0 && halt_req == '0)); // R9

endmodule

// File: rtl/vpc_read_port.sv
module vpc_read_port
  import vpc_pkg::*;
#(
  parameter int NUM_VP = 1,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic [NUM_VP-1:0] running,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] VALID = DATA_W'(vp_mask(NUM_VP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= stat_rd ? DATA_W'(running) : '0;
  end

  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~VALID) == '0); // R1

  AST_READ_ONLY_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> $past(stat_rd)); // R6

endmodule

// File: rtl/vpc_run_ctrl.sv
module vpc_run_ctrl
  import vpc_pkg::*;
#(
  parameter int                NUM_VP        = 1,
  parameter logic [63:0]       START_RUNNING = 64'h1,
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 64,
  parameter logic [ADDR_W-1:0] LOCAL_BASE    = 16'h2000,
  parameter logic [ADDR_W-1:0] REMOTE_BASE   = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_VP-1:0] vp_start_pulse,
  output logic [NUM_VP-1:0] vp_halt_req,
  output logic [NUM_VP-1:0] vp_running
);

  if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_width
    $error("NUM_VP must lie between 1 and DATA_W");
  end

  logic              run_wr;
  logic              stop_wr;
  logic              stat_rd;
  logic [NUM_VP-1:0] cmd_mask;

  // Data bits above the implemented VPs are dropped here.
  assign cmd_mask = bus_wdata[NUM_VP-1:0];

  vpc_addr_decode #(
    .ADDR_W     (ADDR_W),
    .LOCAL_BASE (LOCAL_BASE),
    .REMOTE_BASE(REMOTE_BASE),
    .WIN_SPAN   (256)
  ) i_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .re     (bus_re),
    .run_wr (run_wr),
    .stop_wr(stop_wr),
    .stat_rd(stat_rd)
  );

  vpc_run_state #(
    .NUM_VP       (NUM_VP),
    .START_RUNNING(START_RUNNING)
  ) i_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_wr     (run_wr),
    .stop_wr    (stop_wr),
    .cmd_mask   (cmd_mask),
    .running    (vp_running),
    .start_pulse(vp_start_pulse),
    .halt_req   (vp_halt_req)
  );

  vpc_read_port #(
    .NUM_VP(NUM_VP),
    .DATA_W(DATA_W)
  ) i_read (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_rd(stat_rd),
    .running(vp_running),
    .rdata  (bus_rdata)
  );

  AST_START_HALT_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_start_pulse & vp_halt_req) == '0); // R10

endmodule

// File: tb/test_vpc_run_ctrl.sv
`timescale 1ns/1ps
module test_vpc_run_ctrl;

  localparam int NVP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     bus_addr = '0;
  logic [63:0]     bus_wdata = '0;
  logic            bus_we = 1'b0;
  logic            bus_re = 1'b0;
  logic [63:0]     bus_rdata;
  logic [NVP-1:0]  vp_start_pulse;
  logic [NVP-1:0]  vp_halt_req;
  logic [NVP-1:0]  vp_running;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vpc_run_ctrl #(.NUM_VP(NVP), .START_RUNNING(64'h5)) i_vpc_run_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .vp_start_pulse(vp_start_pulse), .vp_halt_req(vp_halt_req),
    .vp_running(vp_running)
  );

  typedef struct packed {
    logic [15:0]    tag;
    logic [15:0]    addr;
    logic [63:0]    data;
    logic           we;
    logic           re;
    logic [NVP-1:0] e_start;
    logic [NVP-1:0] e_halt;
    logic [NVP-1:0] e_run;
    logic [63:0]    e_rdata;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{"R1", 16'h2000, 64'hFFFF_FFF0_0000_0002, 1'b1, 1'b0, 4'b0010, 4'b0000, 4'b0111, 64'h0}, // out-of-range bits dropped
    '{"R3", 16'h2000, 64'h2,                   1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0111, 64'h0}, // already running
    '{"R6", 16'h2010, 64'h0,                   1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0111, 64'h7}, // status read
    '{"R4", 16'h4008, 64'h3,                   1'b1, 1'b0, 4'b0000, 4'b0011, 4'b0100, 64'h0}, // halt via other window
    '{"R5", 16'h2008, 64'h3,                   1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0100, 64'h0}, // halt again
    '{"R7", 16'h4010, 64'h0,                   1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0100, 64'h4}, // status via other window
    '{"R10",16'h4000, 64'h1,                   1'b1, 1'b0, 4'b0001, 4'b0000, 4'b0101, 64'h0}, // restart after halt
    '{"R8", 16'h2018, 64'hF,                   1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0101, 64'h0}, // bad offset write
    '{"R8", 16'h3000, 64'hF,                   1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0101, 64'h0}, // outside windows
    '{"R8", 16'h2004, 64'h0,                   1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0101, 64'h0}, // bad offset read
    '{"R1", 16'h2008, 64'hF0,                  1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0101, 64'h0}, // halt with high bits only
    '{"R6", 16'h2000, 64'h0,                   1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0101, 64'h0}, // idle, read data zero
    '{"R2", 16'h2000, 64'hF,                   1'b1, 1'b0, 4'b1010, 4'b0000, 4'b1111, 64'h0}, // mixed start mask
    '{"R7", 16'h4010, 64'h0,                   1'b0, 1'b1, 4'b0000, 4'b0000, 4'b1111, 64'hF}  // all running
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic [NVP-1:0] s,
                            input logic [NVP-1:0] h, input logic [NVP-1:0] r,
                            input logic [63:0] d);
    check(req, "start", 64'(vp_start_pulse), 64'(s));
    check(req, "halt", 64'(vp_halt_req), 64'(h));
    check(req, "running", 64'(vp_running), 64'(r));
    check(req, "rdata", bus_rdata, d);
  endtask

  task automatic drive_idle();
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outs("R9", 4'b0000, 4'b0000, 4'b0000, 64'h0); // held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R9", 4'b0101, 4'b0000, 4'b0101, 64'h0); // boot start set
    @(negedge clk);
    check_outs("R2", 4'b0000, 4'b0000, 4'b0101, 64'h0); // pulse lasts one cycle

    for (int i = 0; i < NV; i++) begin
      bus_addr = VEC[i].addr; bus_wdata = VEC[i].data;
      bus_we = VEC[i].we; bus_re = VEC[i].re;
      @(negedge clk);
      check_outs(string'(VEC[i].tag), VEC[i].e_start, VEC[i].e_halt,
                 VEC[i].e_run, VEC[i].e_rdata);
    end
    drive_idle();

    // Halt everything, then reset in the middle of operation.
    bus_addr = 16'h2008; bus_wdata = 64'hF; bus_we = 1'b1;
    @(negedge clk);
    check_outs("R4", 4'b0000, 4'b1111, 4'b0000, 64'h0);
    drive_idle();
    bus_addr = 16'h4000; bus_wdata = 64'h8; bus_we = 1'b1;
    @(negedge clk);
    check_outs("R10", 4'b1000, 4'b0000, 4'b1000, 64'h0);
    drive_idle();
    #1 rst_n = 1'b0;
    #0.5;
    check_outs("R9", 4'b0000, 4'b0000, 4'b0000, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R9", 4'b0101, 4'b0000, 4'b0101, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule